// File: doc/BRIEF.md
# Signed-Digit Constant Multiplier

This block multiplies a signed input word by a coefficient that is fixed when the design is elaborated. It does not build a general array multiplier. A recoding stage turns the coefficient into digits from the set {+1, 0, −1}, using the form that has the fewest nonzero digits. Each nonzero digit contributes a sign-extended copy of the input, shifted left by that digit's position. A +1 digit adds the copy and a −1 digit subtracts it. For a coefficient with long runs of ones, this takes far fewer adders than one adder per set bit. A long run costs one add and one subtract.

The block has no clock. The coefficient enters only as a parameter, so synthesis reduces the recoder to constants. Only the shift-and-add chain remains as logic. The recoder is also a module of its own, with a coefficient input port. A test environment can drive it with any coefficient at run time and examine the digit masks directly.

Top module: `csd_const_mult`

## Requirements
- R1: The output `y` equals the signed product of `x` (two's complement, XW bits) and the non-negative coefficient COEF (CW bits), for every input value. The output is XW+CW+1 bits wide, so the product never overflows.
- R2: The recoder gives two masks of CW+1 bits. A set bit k in `dig_pos` stands for a digit of +2^k. A set bit k in `dig_neg` stands for a digit of −2^k. The two masks never have the same bit set.
- R3: The recoded digits never place two nonzero digits at neighbouring positions.
- R4: The signed sum of the digit weights equals the coefficient. No carry is left beyond position CW.
- R5: The digits match the unique minimal-weight signed-digit form. For example, 15 recodes to +16 −1, which is `dig_pos`=0x010 and `dig_neg`=0x001.
- R6: A power-of-two coefficient 2^k recodes to a single +1 digit at bit k, and the product is `x` shifted left by k.
- R7: The sample coefficients recode as follows: 23 = +32 −8 −1, 29 = +32 −4 +1, 54 = +64 −8 −2.
- R8: A zero coefficient recodes to no digits, and the product is 0 for every `x`.
- R9: For a coefficient whose top bit ends a run of ones, the +1 digit goes into the extra position CW. For example, 255 with CW=8 recodes to +256 −1, which is `dig_pos` bit 8 and `dig_neg` bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | XW | Signed multiplicand, two's complement |
| y | output | XW+CW+1 | Signed product COEF·x |

## Verification
The bench builds eight copies of the multiplier with XW=8 and CW=8. The coefficients are 0, 1, 15, 23, 29, 54, 128 and 255. These cover the zero, power-of-two, sample and top-carry cases. With 8-bit inputs, every one of the 256 input values can be applied to each copy, alongside random values. A separate recoder with CW=8 is driven through all 256 coefficients, so adjacency, disjointness, value and minimality are checked for every possible 8-bit constant.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int CSD_MAXW = 64;

  // Signed value represented by a pair of digit masks.
  function automatic longint csd_value(input logic [CSD_MAXW-1:0] pos,
                                       input logic [CSD_MAXW-1:0] neg);
    longint acc;
    acc = 0;
    for (int i = 0; i < CSD_MAXW - 1; i++) begin
      if (pos[i]) acc = acc + (longint'(1) << i);
      if (neg[i]) acc = acc - (longint'(1) << i);
    end
    return acc;
  endfunction

  // True when no two set bits of the mask are neighbours.
  function automatic logic csd_sparse(input logic [CSD_MAXW-1:0] nz);
    return (nz & (nz >> 1)) == '0;
  endfunction

endpackage

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] coef,
  output logic [CW:0]   dig_pos,
  output logic [CW:0]   dig_neg
);
  localparam int DW = CW + 1;

  logic [DW:0] ext;
  logic [DW:0] carry;

  assign ext      = {2'b00, coef};
  assign carry[0] = 1'b0;

  // One digit cell per position, scanned upward with a carry.
  // A lone one becomes +1. A one with another one above it starts a run:
  // that gives -1 and a carry. A one plus a carry gives 0 and keeps the carry going.
  for (genvar k = 0; k < DW; k++) begin : g_digit
    logic odd_bit;
    logic next_one;
    assign odd_bit      = ext[k] ^ carry[k];
    assign next_one     = ext[k+1];
    assign dig_pos[k]   = odd_bit & ~next_one;
    assign dig_neg[k]   = odd_bit &  next_one;
    assign carry[k+1]   = (ext[k] & carry[k]) | (odd_bit & next_one);
  end

  always_comb begin
    // R2
    pos_neg_disjoint_chk: assert ((dig_pos & dig_neg) == '0)
      else $error("digit both positive and negative");
    // R3
    no_adjacent_chk: assert (csd_pkg::csd_sparse(64'(dig_pos | dig_neg)))
      else $error("adjacent nonzero digits");
    // R4
    value_match_chk: assert (csd_pkg::csd_value(64'(dig_pos), 64'(dig_neg)) == longint'(coef))
      else $error("digit value differs from coefficient");
    // R4
    no_carry_out_chk: assert (carry[DW] == 1'b0)
      else $error("carry past top digit");
    // R5
    min_weight_chk: assert ($countones({dig_pos, dig_neg}) <= $countones(coef))
      else $error("more digits than set bits");
  end

endmodule

// File: rtl/csd_term.sv
module csd_term #(
  parameter int XW = 8,
  parameter int YW = 17,
  parameter int K  = 0
) (
  input  logic [XW-1:0]        x,
  input  logic                 add_en,
  input  logic                 sub_en,
  output logic signed [YW-1:0] term
);
  logic signed [YW-1:0] x_ext;
  logic signed [YW-1:0] x_shift;

  assign x_ext   = YW'($signed(x));
  assign x_shift = x_ext <<< K;

  always_comb begin
    if (add_en)      term = x_shift;
    else if (sub_en) term = -x_shift;
    else             term = '0;
  end

  always_comb begin
    // R2
    term_sign_chk: assert (!(add_en && sub_en))
      else $error("term asked to add and subtract");
  end

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
  parameter int XW   = 8,
  parameter int CW   = 8,
  parameter int COEF = 54
) (
  input  logic [XW-1:0]          x,
  output logic signed [XW+CW:0]  y
);
  localparam int YW = XW + CW + 1;
  localparam int DW = CW + 1;
  localparam logic [CW-1:0] COEF_V = CW'(COEF);

  logic [DW-1:0]        dig_pos;
  logic [DW-1:0]        dig_neg;
  logic signed [YW-1:0] partial [DW+1];

  csd_recoder #(.CW(CW)) u_rec (
    .coef    (COEF_V),
    .dig_pos (dig_pos),
    .dig_neg (dig_neg)
  );

  assign partial[0] = '0;

  for (genvar k = 0; k < DW; k++) begin : g_term
    logic signed [YW-1:0] term;
    csd_term #(.XW(XW), .YW(YW), .K(k)) u_term (
      .x      (x),
      .add_en (dig_pos[k]),
      .sub_en (dig_neg[k]),
      .term   (term)
    );
    assign partial[k+1] = partial[k] + term;
  end

  assign y = partial[DW];

  // Product from a generic multiply, used only for checking.
  logic signed [YW-1:0] ref_prod;
  assign ref_prod = $signed({{(YW-XW){x[XW-1]}}, x}) * $signed({{(YW-CW){1'b0}}, COEF_V});

  always_comb begin
    // R1
    product_match_chk: assert (y == ref_prod)
      else $error("product mismatch");
    // R8
    zero_coef_chk: assert (COEF_V != '0 || y == '0)
      else $error("nonzero output for zero coefficient");
  end

endmodule

// File: tb/csd_const_mult_bench.sv
module csd_const_mult_bench;
  localparam int XW = 8;
  localparam int CW = 8;
  localparam int YW = XW + CW + 1;
  localparam int NI = 8;
  localparam int KC [NI] = '{0, 1, 15, 23, 29, 54, 128, 255};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [XW-1:0]        x = '0;
  logic signed [YW-1:0] y_all [NI];

  for (genvar g = 0; g < NI; g++) begin : g_inst
    csd_const_mult #(.XW(XW), .CW(CW), .COEF(KC[g])) u_csd_const_mult (
      .x (x),
      .y (y_all[g])
    );
  end

  logic [CW-1:0] coef = '0;
  logic [CW:0]   dpos;
  logic [CW:0]   dneg;
  csd_recoder #(.CW(CW)) u_rec (.coef(coef), .dig_pos(dpos), .dig_neg(dneg));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference product from the plain binary bits of the coefficient.
  function automatic longint ref_mult(input int xv, input int c);
    longint acc = 0;
    for (int i = 0; i < 31; i++)
      if (c[i]) acc += longint'(xv) <<< i;
    return acc;
  endfunction

  // Minimal-weight digits obtained by repeated reduction modulo 4.
  function automatic void ref_naf(input int c, output int pm, output int nm);
    int v = c;
    pm = 0; nm = 0;
    for (int k = 0; k < 32 && v != 0; k++) begin
      if (v % 2 != 0) begin
        if (v % 4 == 1) begin pm |= (1 << k); v = v - 1; end
        else            begin nm |= (1 << k); v = v + 1; end
      end
      v = v / 2;
    end
  endfunction

  task automatic apply_x(input int xv);
    x = XW'(xv);
    #1;
    for (int g = 0; g < NI; g++) begin
      if (KC[g] == 0)        check("R8", longint'(y_all[g]), 0);
      else if (KC[g] == 128) check("R6", longint'(y_all[g]), longint'(xv) <<< 7);
      else                   check("R1", longint'(y_all[g]), ref_mult(xv, KC[g]));
    end
  endtask

  task automatic apply_coef(input int c);
    int pm, nm;
    coef = CW'(c);
    #1;
    ref_naf(c, pm, nm);
    check("R2", longint'(dpos & dneg), 0);
    check("R3", longint'((dpos | dneg) & ((dpos | dneg) >> 1)), 0);
    check("R4", csd_pkg::csd_value(64'(dpos), 64'(dneg)), longint'(c));
    check("R5", longint'({dpos, dneg}), longint'({pm[CW:0], nm[CW:0]}));
  endtask

  initial begin : stim
    int seed_val;
    seed_val = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state-like start: zero input gives zero product everywhere (R1)
    x = '0; #1;
    for (int g = 0; g < NI; g++) check("R1", longint'(y_all[g]), 0);
    // Directed extremes of x
    apply_x(-128); apply_x(127); apply_x(-1); apply_x(1);
    // Exhaustive input sweep
    for (int xv = -128; xv < 128; xv++) apply_x(xv);
    // Random inputs
    repeat (200) apply_x(int'($urandom_range(255, 0)) - 128);
    // Directed recodings
    coef = 8'd23; #1; check("R7", longint'({dpos, dneg}), longint'({9'h020, 9'h009}));
    coef = 8'd29; #1; check("R7", longint'({dpos, dneg}), longint'({9'h021, 9'h004}));
    coef = 8'd54; #1; check("R7", longint'({dpos, dneg}), longint'({9'h040, 9'h00A}));
    coef = 8'd15; #1; check("R5", longint'({dpos, dneg}), longint'({9'h010, 9'h001}));
    coef = 8'd128; #1; check("R6", longint'({dpos, dneg}), longint'({9'h080, 9'h000}));
    coef = 8'd1;  #1; check("R6", longint'({dpos, dneg}), longint'({9'h001, 9'h000}));
    coef = 8'd0;  #1; check("R8", longint'({dpos, dneg}), 0);
    coef = 8'd255; #1; check("R9", longint'({dpos, dneg}), longint'({9'h100, 9'h001}));
    coef = 8'd192; #1; check("R9", longint'({dpos, dneg}), longint'({9'h100, 9'h040}));
    // Every coefficient, then random repeats
    for (int c = 0; c < 256; c++) apply_coef(c);
    repeat (64) apply_coef(int'($urandom_range(255, 0)));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule